// File: doc/BRIEF.md
# Bus Command Responder

This block sits behind the byte receiver of an IEEE-488 style instrument port. It acts on the command bytes that arrive while ATN is true. Every byte that comes with a valid strobe and ATN asserted is decoded on its low seven bits. Universal and addressed commands are then handled as follows:

- A device clear, whether universal or addressed to the listener, raises a sticky flag. The flag can request an interrupt.
- The serial-poll enable and disable commands switch a poll mode. While that mode is on and the card is addressed to talk, a host-loaded response byte replaces normal data.
- A take-control command sent to the addressed talker hands the controller role to the card once ATN drops.

Parallel poll is answered directly from two switch inputs, one choosing the line and one choosing the sense, whenever ATN and EOI are both true. The configure and unconfigure commands have no effect. The host only loads the serial poll response byte and clears the device-clear flag. The rest happens without it.

Top module: `bus_cmd_responder`

## Requirements
- R1: After reset, dev_clr_flag, spoll_mode, take_ctrl, irq and resp_sel are all 0.
- R2: A strobed byte with atn=1 whose low seven bits are 0x14, or are 0x04 while addr_listen=1, sets dev_clr_flag at the next clock edge, but only when is_ctrl=0. If the same edge has both a set and dc_clr, the set wins.
- R3: irq equals dev_clr_flag AND irq_mask_dc with no clock delay. A dc_clr pulse with no set at the same edge clears dev_clr_flag at that edge.
- R4: Codes 0x01, 0x11, 0x08, 0x05 and 0x15, and every code that is not listed in R2, R5 or R9, leave dev_clr_flag, spoll_mode, take_ctrl and pp_lines unchanged.
- R5: A strobed code 0x18 with atn=1 sets spoll_mode at the next edge. Code 0x19 clears it.
- R6: While spoll_mode=1 and addr_talk=1, resp_sel=1 and resp_byte is the stored byte with bit 6 replaced by host_srq. Otherwise resp_sel=0.
- R7: host_wr=1 loads host_wdata into the stored response byte at the next edge.
- R8: pp_lines is one-hot at bit pp_sel_sw when atn=1, eoi=1 and ist equals pp_sense_sw. Otherwise it is all zero. In the default variant it has no clock delay.
- R9: A strobed code 0x09 with atn=1 and addr_talk=1 arms a transfer. At the first edge that sees atn=0, take_ctrl goes high for exactly one cycle. The code with addr_talk=0 is ignored.
- R10: Strobed bytes with atn=0 are ignored. Bit 7 of the command byte never affects decoding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Received byte strobe |
| cmd_byte | input | DATA_W | Received byte |
| atn | input | 1 | Attention line state |
| eoi | input | 1 | End-or-identify line state |
| addr_listen | input | 1 | Card is addressed as listener |
| addr_talk | input | 1 | Card is addressed as talker |
| is_ctrl | input | 1 | Card is currently active controller |
| dc_clr | input | 1 | Host clears the device-clear flag |
| irq_mask_dc | input | 1 | Interrupt enable for device clear |
| host_wr | input | 1 | Host write strobe for the poll response |
| host_wdata | input | DATA_W | Poll response byte from host |
| host_srq | input | 1 | Card's own pending service request |
| ist | input | 1 | Local status bit for parallel poll |
| pp_sel_sw | input | PP_SEL_W | Switch: parallel poll data line |
| pp_sense_sw | input | 1 | Switch: parallel poll sense |
| dev_clr_flag | output | 1 | Sticky device-clear flag |
| irq | output | 1 | Interrupt request |
| spoll_mode | output | 1 | Serial poll mode active |
| resp_sel | output | 1 | Transmit path takes resp_byte |
| resp_byte | output | DATA_W | Serial poll status byte |
| pp_lines | output | PP_LINES | Parallel poll line drive (true-asserted) |
| take_ctrl | output | 1 | One-cycle pulse: assume controller role |

## Verification
The device-clear flag, the poll mode and the stored response byte are registered, so each one changes at the first clock edge after its strobe. The bench checks them one settle step after that edge. irq, resp_sel, resp_byte and pp_lines are combinational, so they are checked one settle step after their inputs change, with no edge in between. The take-control pulse is due at the edge after the arming edge, if ATN is low there. The bench checks that it is absent while ATN stays high, present for the first cycle after release, and gone one cycle later.

// File: rtl/bcr_pkg.sv
package bcr_pkg;
   localparam int CMD_W = 7;

   typedef enum logic [CMD_W-1:0] {
      K_GTL = 7'h01,
      K_SDC = 7'h04,
      K_PPC = 7'h05,
      K_GET = 7'h08,
      K_TCT = 7'h09,
      K_LLO = 7'h11,
      K_DCL = 7'h14,
      K_PPU = 7'h15,
      K_SPE = 7'h18,
      K_SPD = 7'h19
   } bus_cmd_e;

   typedef struct packed {
      logic dev_clr;
      logic sp_on;
      logic sp_off;
      logic tct_arm;
   } cmd_hit_t;
endpackage

// File: rtl/bcr_decode.sv
module bcr_decode
   import bcr_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              cmd_valid,
   input  logic [DATA_W-1:0] cmd_byte,
   input  logic              atn,
   input  logic              addr_listen,
   input  logic              addr_talk,
   input  logic              is_ctrl,
   output cmd_hit_t          hit
);
   localparam int HI_W = DATA_W - CMD_W;

   logic [CMD_W-1:0] code;
   logic             take;
   logic             unused_hi;

   assign code      = cmd_byte[CMD_W-1:0];
   assign take      = cmd_valid & atn;
   assign unused_hi = &{1'b0, cmd_byte[DATA_W-1:CMD_W]};

   always_comb begin
      hit = '0;
      if (take) begin
         case (code)
            K_DCL:   hit.dev_clr = ~is_ctrl;
            K_SDC:   hit.dev_clr = ~is_ctrl & addr_listen;
            K_SPE:   hit.sp_on   = 1'b1;
            K_SPD:   hit.sp_off  = 1'b1;
            K_TCT:   hit.tct_arm = addr_talk;
            K_GTL, K_LLO, K_GET, K_PPC, K_PPU: hit = '0;
            default: hit = '0;
         endcase
      end
   end

   initial begin
      if (HI_W < 1) $error("bcr_decode: DATA_W must exceed the command width");
   end
endmodule

// File: rtl/bcr_ctrl.sv
module bcr_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic dc_set,
   input  logic dc_clr,
   input  logic irq_mask_dc,
   input  logic tct_arm,
   input  logic atn,
   output logic dev_clr_flag,
   output logic irq,
   output logic take_ctrl
);
   logic tct_pend;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dev_clr_flag <= 1'b0;
      end else if (dc_set) begin
         dev_clr_flag <= 1'b1;
      end else if (dc_clr) begin
         dev_clr_flag <= 1'b0;
      end
   end

   assign irq = dev_clr_flag & irq_mask_dc;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tct_pend  <= 1'b0;
         take_ctrl <= 1'b0;
      end else begin
         take_ctrl <= tct_pend & ~atn;
         if (tct_pend & ~atn) tct_pend <= 1'b0;
         else if (tct_arm)    tct_pend <= 1'b1;
      end
   end

   p_dc_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
      dc_set |=> dev_clr_flag);
   p_dc_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (dc_clr && !dc_set) |=> !dev_clr_flag);
   p_irq_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_mask_dc |-> !irq);
   p_take_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      take_ctrl |=> !take_ctrl);
   p_take_after_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(take_ctrl) |-> !$past(atn));
endmodule

// File: rtl/bcr_spoll.sv
module bcr_spoll #(
   parameter int DATA_W  = 8,
   parameter int SRQ_BIT = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sp_on,
   input  logic              sp_off,
   input  logic              host_wr,
   input  logic [DATA_W-1:0] host_wdata,
   input  logic              host_srq,
   input  logic              addr_talk,
   output logic              spoll_mode,
   output logic              resp_sel,
   output logic [DATA_W-1:0] resp_byte
);
   logic [DATA_W-1:0] stored;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         spoll_mode <= 1'b0;
      end else if (sp_on) begin
         spoll_mode <= 1'b1;
      end else if (sp_off) begin
         spoll_mode <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       stored <= '0;
      else if (host_wr) stored <= host_wdata;
   end

   assign resp_sel = spoll_mode & addr_talk;

   always_comb begin
      resp_byte          = stored;
      resp_byte[SRQ_BIT] = host_srq;
   end

   initial begin
      if (SRQ_BIT >= DATA_W) $error("bcr_spoll: SRQ_BIT outside the byte");
   end

   p_spe_r5: assert property (@(posedge clk) disable iff (!rst_n)
      sp_on |=> spoll_mode);
   p_spd_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (sp_off && !sp_on) |=> !spoll_mode);
   p_sel_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !spoll_mode |-> !resp_sel);
   p_srq_r6: assert property (@(posedge clk) disable iff (!rst_n)
      resp_byte[SRQ_BIT] == host_srq);
endmodule

// File: rtl/bcr_ppoll.sv
module bcr_ppoll #(
   parameter int PP_LINES = 8,
   parameter bit PP_REG   = 1'b0,
   localparam int SEL_W   = (PP_LINES > 1) ? $clog2(PP_LINES) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                atn,
   input  logic                eoi,
   input  logic                ist,
   input  logic [SEL_W-1:0]    pp_sel_sw,
   input  logic                pp_sense_sw,
   output logic [PP_LINES-1:0] pp_lines
);
   logic                poll;
   logic [PP_LINES-1:0] drive;

   assign poll = atn & eoi & (ist == pp_sense_sw);

   always_comb begin
      drive = '0;
      for (int i = 0; i < PP_LINES; i++) begin
         if (poll && (pp_sel_sw == SEL_W'(i))) drive[i] = 1'b1;
      end
   end

   generate
      if (PP_REG) begin : g_reg
         always_ff @(posedge clk) begin
            if (!rst_n) pp_lines <= '0;
            else        pp_lines <= drive;
         end
      end else begin : g_comb
         logic unused_clk;
         assign unused_clk = &{1'b0, clk, rst_n};
         assign pp_lines   = drive;
      end
   endgenerate

   initial begin
      if (PP_LINES < 1 || PP_LINES > 8) $error("bcr_ppoll: PP_LINES out of range");
   end

   p_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(pp_lines));
   p_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(atn && eoi) && !PP_REG |-> pp_lines == '0);
endmodule

// File: rtl/bus_cmd_responder.sv
module bus_cmd_responder
   import bcr_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int PP_LINES = 8,
   parameter bit PP_REG   = 1'b0,
   parameter int SRQ_BIT  = 6,
   localparam int PP_SEL_W = (PP_LINES > 1) ? $clog2(PP_LINES) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cmd_valid,
   input  logic [DATA_W-1:0]   cmd_byte,
   input  logic                atn,
   input  logic                eoi,
   input  logic                addr_listen,
   input  logic                addr_talk,
   input  logic                is_ctrl,
   input  logic                dc_clr,
   input  logic                irq_mask_dc,
   input  logic                host_wr,
   input  logic [DATA_W-1:0]   host_wdata,
   input  logic                host_srq,
   input  logic                ist,
   input  logic [PP_SEL_W-1:0] pp_sel_sw,
   input  logic                pp_sense_sw,
   output logic                dev_clr_flag,
   output logic                irq,
   output logic                spoll_mode,
   output logic                resp_sel,
   output logic [DATA_W-1:0]   resp_byte,
   output logic [PP_LINES-1:0] pp_lines,
   output logic                take_ctrl
);
   cmd_hit_t hit;

   bcr_decode #(.DATA_W(DATA_W)) u_dec (
      .cmd_valid  (cmd_valid),
      .cmd_byte   (cmd_byte),
      .atn        (atn),
      .addr_listen(addr_listen),
      .addr_talk  (addr_talk),
      .is_ctrl    (is_ctrl),
      .hit        (hit)
   );

   bcr_ctrl u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .dc_set      (hit.dev_clr),
      .dc_clr      (dc_clr),
      .irq_mask_dc (irq_mask_dc),
      .tct_arm     (hit.tct_arm),
      .atn         (atn),
      .dev_clr_flag(dev_clr_flag),
      .irq         (irq),
      .take_ctrl   (take_ctrl)
   );

   bcr_spoll #(.DATA_W(DATA_W), .SRQ_BIT(SRQ_BIT)) u_sp (
      .clk       (clk),
      .rst_n     (rst_n),
      .sp_on     (hit.sp_on),
      .sp_off    (hit.sp_off),
      .host_wr   (host_wr),
      .host_wdata(host_wdata),
      .host_srq  (host_srq),
      .addr_talk (addr_talk),
      .spoll_mode(spoll_mode),
      .resp_sel  (resp_sel),
      .resp_byte (resp_byte)
   );

   bcr_ppoll #(.PP_LINES(PP_LINES), .PP_REG(PP_REG)) u_pp (
      .clk        (clk),
      .rst_n      (rst_n),
      .atn        (atn),
      .eoi        (eoi),
      .ist        (ist),
      .pp_sel_sw  (pp_sel_sw),
      .pp_sense_sw(pp_sense_sw),
      .pp_lines   (pp_lines)
   );

   p_no_atn_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !atn && !dc_clr) |=> $stable(dev_clr_flag));
   p_ctrl_blocks_dc_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (is_ctrl && !dc_clr && !dev_clr_flag) |=> !dev_clr_flag);
endmodule

// File: tb/bus_cmd_responder_test.sv
module bus_cmd_responder_test;
   localparam int CLK_P = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmd_valid = 0, atn = 0, eoi = 0, addr_listen = 0, addr_talk = 0;
   logic       is_ctrl = 0, dc_clr = 0, irq_mask_dc = 0, host_wr = 0, host_srq = 0;
   logic       ist = 0, pp_sense_sw = 0;
   logic [7:0] cmd_byte = 0, host_wdata = 0;
   logic [2:0] pp_sel_sw = 0;
   logic       dev_clr_flag, irq, spoll_mode, resp_sel, take_ctrl;
   logic [7:0] resp_byte, pp_lines;

   int checks = 0;
   int fails = 0;
   int cycles = 0;

   always #(CLK_P/2) clk = ~clk;

   bus_cmd_responder uut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
      .atn(atn), .eoi(eoi), .addr_listen(addr_listen), .addr_talk(addr_talk),
      .is_ctrl(is_ctrl), .dc_clr(dc_clr), .irq_mask_dc(irq_mask_dc),
      .host_wr(host_wr), .host_wdata(host_wdata), .host_srq(host_srq),
      .ist(ist), .pp_sel_sw(pp_sel_sw), .pp_sense_sw(pp_sense_sw),
      .dev_clr_flag(dev_clr_flag), .irq(irq), .spoll_mode(spoll_mode),
      .resp_sel(resp_sel), .resp_byte(resp_byte), .pp_lines(pp_lines),
      .take_ctrl(take_ctrl)
   );

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 150000) begin
         fails = fails + 1;
         $display("FAIL watchdog: run did not finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks = checks + 1;
      if (act !== exp) begin
         fails = fails + 1;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic send(input logic [7:0] b);
      cmd_valid = 1; cmd_byte = b;
      step();
      cmd_valid = 0;
   endtask

   initial begin
      logic [7:0] exp_pp;
      logic [6:0] lo;
      rst_n = 0;
      step(); step();
      rst_n = 1;
      #1;
      // R1 reset state
      chk("R1 dev_clr_flag", dev_clr_flag, 0);
      chk("R1 spoll_mode", spoll_mode, 0);
      chk("R1 take_ctrl", take_ctrl, 0);
      chk("R1 irq", irq, 0);
      chk("R1 resp_sel", resp_sel, 0);

      // R2 R4 R5 R10: sweep of every byte value
      atn = 1; addr_listen = 1; addr_talk = 0; is_ctrl = 0;
      for (int c = 0; c < 256; c++) begin
         dc_clr = 1; send(8'h19); dc_clr = 0;
         send(c[7:0]);
         lo = c[6:0];
         chk("R2/R4/R10 dev_clr sweep", dev_clr_flag, (lo == 7'h14 || lo == 7'h04));
         chk("R5/R4/R10 spoll sweep", spoll_mode, (lo == 7'h18));
         chk("R4 take_ctrl sweep", take_ctrl, 0);
      end
      dc_clr = 1; send(8'h19); dc_clr = 0;

      // R2 addressed clear needs listener, controller blocks
      addr_listen = 0; send(8'h04);
      chk("R2 SDC unaddressed", dev_clr_flag, 0);
      is_ctrl = 1; send(8'h14);
      chk("R2 DCL while controller", dev_clr_flag, 0);
      is_ctrl = 0;
      // R2 set wins over clear
      dc_clr = 1; send(8'h14); dc_clr = 0;
      chk("R2 set wins", dev_clr_flag, 1);

      // R3 interrupt masking and clear
      irq_mask_dc = 0; #1;
      chk("R3 irq masked", irq, 0);
      irq_mask_dc = 1; #1;
      chk("R3 irq enabled", irq, 1);
      dc_clr = 1; step(); dc_clr = 0;
      chk("R3 flag cleared", dev_clr_flag, 0);
      chk("R3 irq after clear", irq, 0);

      // R10 bytes without ATN
      atn = 0; send(8'h14);
      chk("R10 DCL without atn", dev_clr_flag, 0);
      send(8'h18);
      chk("R10 SPE without atn", spoll_mode, 0);
      atn = 1;

      // R7 R6 serial poll response
      host_wr = 1; host_wdata = 8'hA5; step(); host_wr = 0;
      send(8'h18);
      chk("R5 SPE", spoll_mode, 1);
      addr_talk = 1; host_srq = 1; #1;
      chk("R6 resp_sel", resp_sel, 1);
      chk("R6/R7 byte with srq", resp_byte, 8'hE5);
      host_srq = 0; #1;
      chk("R6/R7 byte no srq", resp_byte, 8'hA5);
      host_wr = 1; host_wdata = 8'h5A; step(); host_wr = 0;
      chk("R7 reload", resp_byte, 8'h1A);
      addr_talk = 0; #1;
      chk("R6 not talker", resp_sel, 0);
      addr_talk = 1;
      send(8'h19);
      chk("R5 SPD", spoll_mode, 0);
      chk("R6 after SPD", resp_sel, 0);

      // R9 take control
      addr_talk = 1; atn = 1; send(8'h09);
      chk("R9 no pulse while atn", take_ctrl, 0);
      step();
      chk("R9 held by atn", take_ctrl, 0);
      atn = 0; step();
      chk("R9 pulse", take_ctrl, 1);
      step();
      chk("R9 single cycle", take_ctrl, 0);
      atn = 1; addr_talk = 0; send(8'h09);
      atn = 0; step(); step();
      chk("R9 not talker", take_ctrl, 0);
      atn = 1;

      // R8 parallel poll sweep
      for (int s = 0; s < 8; s++)
         for (int sn = 0; sn < 2; sn++)
            for (int st = 0; st < 2; st++)
               for (int ae = 0; ae < 4; ae++) begin
                  pp_sel_sw = s[2:0]; pp_sense_sw = sn[0]; ist = st[0];
                  atn = ae[0]; eoi = ae[1];
                  #1;
                  exp_pp = (ae == 3 && st == sn) ? (8'd1 << s) : 8'd0;
                  chk("R8 pp sweep", pp_lines, exp_pp);
               end

      // R4 configure/unconfigure ignored
      atn = 1; eoi = 0; pp_sel_sw = 3; pp_sense_sw = 1; ist = 1;
      send(8'h05); send(8'h63); send(8'h15);
      eoi = 1; #1;
      chk("R4 pp after PPC/PPU", pp_lines, 8'h08);
      eoi = 0;

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule